// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt sources and presents a processor with one prioritised request. Each source can be raised by a level-sensitive hardware line or by a bit that software sets. The combined request is gated by a per-source enable mask. Every source has its own configuration word, which holds a priority level, a target register-set number and a non-maskable flag. Each cycle the controller picks the enabled, requesting source with the highest level. From the selected source number it computes a handler address: a programmable table base plus the index scaled by a programmable entry size.

The result goes to the processor as a registered packet. The packet holds a strobe, the handler address, the register set, the level and the non-maskable flag. All state is reached through a 32-bit word-addressed register port. The port accepts single full-word writes, and read data is returned combinationally in the same cycle. The enable mask and the software request bits each have a plain register and separate set and clear aliases, so one bit can be changed without a read-modify-write.

Top module: `vpic_top`

## Requirements
- R1: The pending set, readable at word 35, equals (hardware request lines OR software request bits) AND the enable mask, with bit i belonging to source i.
- R2: Configuration word i sits at word offset i (0 to 31) and reads back as written. Its bits [5:0] are the level, bit 6 is the non-maskable flag and bits [12:7] are the register set.
- R3: The selected source is the pending source with the strictly greatest level, and the lowest index wins a tie. A source with level 0 is never selected, even when pending.
- R4: The handler address is the table base (word 42) plus the selected index shifted left by 2 + control[2:0], where control is word 40. Control bits above bit 2 have no effect on the address.
- R5: The status word (41) reads bit 31 set plus the selected index in the low bits. The status word and the vector-address word (43) both read 0 while nothing is selected.
- R6: The strobe `req_o` is high only while a source is selected. `req_level_o`, `req_rset_o` and `req_nmi_o` carry the fields of the selected source's configuration word, and `req_addr_o` carries the R4 address.
- R7: Writing word 33 ORs the data into the enable mask (word 32), and writing word 34 clears the written bits from it. Words 38 and 39 do the same for the software request bits (word 37).
- R8: The alias words 33, 34, 38, 39 and the unmapped words 44 to 63 read as 0. Writes to the read-only words 35, 36, 41 and 43 and to unmapped words change no state.
- R9: Word 36 reads the present level of the hardware request lines.
- R10: After reset every configuration word, the enable mask, the software bits, the control, base, status and vector-address words read 0, and the strobe is low.
- R11: The packet outputs and words 41 and 43 change on the first clock edge after the change in a request line or register that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Level-sensitive hardware request lines |
| csr_valid_i | input | 1 | Register access strobe |
| csr_write_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 6 | Word offset |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, valid in the same cycle |
| req_o | output | 1 | Interrupt request strobe to the processor |
| req_addr_o | output | 32 | Handler address |
| req_rset_o | output | 6 | Requested register set |
| req_level_o | output | 6 | Requested level |
| req_nmi_o | output | 1 | Non-maskable request flag |

## Verification
The hardest situation to reach is a tie, or a masked winner, while several sources assert at once from both hardware lines and software bits. In such a case the lowest index must win over an equal level, a higher level must lose once its enable bit is cleared, and a pending source with level 0 must stay invisible. The stimulus first programs a sparse set of configuration words with deliberately equal and extreme levels. It then walks a vector table that combines request lines, software bits and enable masks so that each of these conflicts occurs, and it checks the packet and the status words against an address computed from base and entry size.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned FIELD_W  = 6;
    localparam int unsigned OFF_EN    = 32;
    localparam int unsigned OFF_ENSET = 33;
    localparam int unsigned OFF_ENCLR = 34;
    localparam int unsigned OFF_PEND  = 35;
    localparam int unsigned OFF_RAW   = 36;
    localparam int unsigned OFF_SW    = 37;
    localparam int unsigned OFF_SWSET = 38;
    localparam int unsigned OFF_SWCLR = 39;
    localparam int unsigned OFF_CTRL  = 40;
    localparam int unsigned OFF_STAT  = 41;
    localparam int unsigned OFF_BASE  = 42;
    localparam int unsigned OFF_VADDR = 43;
    localparam int unsigned LVL_LSB  = 0;
    localparam int unsigned NMI_BIT  = 6;
    localparam int unsigned RSET_LSB = 7;
endpackage

// File: rtl/vpic_csr.sv
module vpic_csr
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_IN = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           csr_valid_i,
    input  logic                           csr_write_i,
    input  logic [ADDR_W-1:0]              csr_addr_i,
    input  logic [DATA_W-1:0]              csr_wdata_i,
    output logic [DATA_W-1:0]              csr_rdata_o,
    input  logic [NUM_IN-1:0]              raw_i,
    input  logic [DATA_W-1:0]              status_i,
    input  logic [DATA_W-1:0]              vaddr_i,
    output logic [NUM_IN-1:0][DATA_W-1:0]  cfg_o,
    output logic [NUM_IN-1:0]              pending_o,
    output logic [DATA_W-1:0]              ctrl_o,
    output logic [DATA_W-1:0]              base_o
);
    localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    typedef struct packed {
        logic [NUM_IN-1:0][DATA_W-1:0] cfg;
        logic [NUM_IN-1:0]             en;
        logic [NUM_IN-1:0]             sw;
        logic [DATA_W-1:0]             ctrl;
        logic [DATA_W-1:0]             base;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_en;
    logic [NUM_IN-1:0] wmask;

    assign wr_en = csr_valid_i && csr_write_i;
    assign wmask = csr_wdata_i[NUM_IN-1:0];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (int'(csr_addr_i) < int'(NUM_IN)) begin
                regs_d.cfg[csr_addr_i[IDX_W-1:0]] = csr_wdata_i;
            end
            case (int'(csr_addr_i))
                OFF_EN:    regs_d.en   = wmask;
                OFF_ENSET: regs_d.en   = regs_q.en | wmask;
                OFF_ENCLR: regs_d.en   = regs_q.en & ~wmask;
                OFF_SW:    regs_d.sw   = wmask;
                OFF_SWSET: regs_d.sw   = regs_q.sw | wmask;
                OFF_SWCLR: regs_d.sw   = regs_q.sw & ~wmask;
                OFF_CTRL:  regs_d.ctrl = csr_wdata_i;
                OFF_BASE:  regs_d.base = csr_wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pending_o = (raw_i | regs_q.sw) & regs_q.en;
    assign cfg_o     = regs_q.cfg;
    assign ctrl_o    = regs_q.ctrl;
    assign base_o    = regs_q.base;

    always_comb begin
        csr_rdata_o = '0;
        if (int'(csr_addr_i) < int'(NUM_IN)) begin
            csr_rdata_o = regs_q.cfg[csr_addr_i[IDX_W-1:0]];
        end
        case (int'(csr_addr_i))
            OFF_EN:    csr_rdata_o = DATA_W'(regs_q.en);
            OFF_PEND:  csr_rdata_o = DATA_W'(pending_o);
            OFF_RAW:   csr_rdata_o = DATA_W'(raw_i);
            OFF_SW:    csr_rdata_o = DATA_W'(regs_q.sw);
            OFF_CTRL:  csr_rdata_o = regs_q.ctrl;
            OFF_STAT:  csr_rdata_o = status_i;
            OFF_BASE:  csr_rdata_o = regs_q.base;
            OFF_VADDR: csr_rdata_o = vaddr_i;
            default:   ;
        endcase
    end

    // set alias leaves every written bit set
    assert_enset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(csr_addr_i) == OFF_ENSET) |=> ((regs_q.en & $past(wmask)) == $past(wmask)));
    // clear alias leaves every written bit clear
    assert_swclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(csr_addr_i) == OFF_SWCLR) |=> ((regs_q.sw & $past(wmask)) == '0));
    // a write to a read-only word leaves the state alone
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(csr_addr_i) == OFF_PEND || int'(csr_addr_i) == OFF_RAW ||
                   int'(csr_addr_i) == OFF_STAT || int'(csr_addr_i) == OFF_VADDR))
        |=> ($stable(regs_q.en) && $stable(regs_q.sw) && $stable(regs_q.ctrl) && $stable(regs_q.base)));
endmodule

// File: rtl/vpic_pick.sv
module vpic_pick
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_IN = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_IN-1:0]              pending_i,
    input  logic [NUM_IN-1:0][DATA_W-1:0]  cfg_i,
    output logic                           sel_valid_o,
    output logic [$clog2(NUM_IN)-1:0]      sel_idx_o,
    output logic [FIELD_W-1:0]             sel_level_o,
    output logic [FIELD_W-1:0]             sel_rset_o,
    output logic                           sel_nmi_o
);
    localparam int unsigned IDX_W = $clog2(NUM_IN);

    logic [NUM_IN-1:0][FIELD_W-1:0] lvl;
    logic [NUM_IN-1:0][FIELD_W-1:0] rset;
    logic [NUM_IN-1:0]              nmi;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_fields
        assign lvl[g]  = cfg_i[g][LVL_LSB  +: FIELD_W];
        assign rset[g] = cfg_i[g][RSET_LSB +: FIELD_W];
        assign nmi[g]  = cfg_i[g][NMI_BIT];
    end

    // strict compare keeps the lowest index on equal levels; level 0 never wins
    always_comb begin
        sel_valid_o = 1'b0;
        sel_idx_o   = '0;
        sel_level_o = '0;
        for (int i = 0; i < int'(NUM_IN); i++) begin
            if (pending_i[i] && (lvl[i] > sel_level_o)) begin
                sel_valid_o = 1'b1;
                sel_idx_o   = IDX_W'(i);
                sel_level_o = lvl[i];
            end
        end
        sel_rset_o = rset[sel_idx_o];
        sel_nmi_o  = nmi[sel_idx_o];
    end

    assert_pick_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (pending_i[sel_idx_o] && lvl[sel_idx_o] != '0));
    assert_pick_any_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_i & ~pending_i) == '0 && !sel_valid_o) |-> (sel_level_o == '0));
endmodule

// File: rtl/vpic_pkt.sv
module vpic_pkt
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_IN = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_valid_i,
    input  logic [$clog2(NUM_IN)-1:0]  sel_idx_i,
    input  logic [FIELD_W-1:0]         sel_level_i,
    input  logic [FIELD_W-1:0]         sel_rset_i,
    input  logic                       sel_nmi_i,
    input  logic [2:0]                 size_sel_i,
    input  logic [DATA_W-1:0]          base_i,
    output logic                       req_o,
    output logic [DATA_W-1:0]          addr_o,
    output logic [FIELD_W-1:0]         rset_o,
    output logic [FIELD_W-1:0]         level_o,
    output logic                       nmi_o,
    output logic [DATA_W-1:0]          status_o
);
    localparam int unsigned IDX_W = $clog2(NUM_IN);

    typedef struct packed {
        logic               req;
        logic [DATA_W-1:0]  addr;
        logic [FIELD_W-1:0] rset;
        logic [FIELD_W-1:0] level;
        logic               nmi;
        logic [DATA_W-1:0]  status;
    } pkt_t;

    pkt_t pkt_d, pkt_q;
    logic [3:0] shamt;

    assign shamt = 4'(size_sel_i) + 4'd2;

    always_comb begin
        pkt_d = '0;
        if (sel_valid_i) begin
            pkt_d.req    = 1'b1;
            pkt_d.addr   = base_i + (DATA_W'(sel_idx_i) << shamt);
            pkt_d.rset   = sel_rset_i;
            pkt_d.level  = sel_level_i;
            pkt_d.nmi    = sel_nmi_i;
            pkt_d.status = {1'b1, {(DATA_W-1-IDX_W){1'b0}}, sel_idx_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pkt_q <= '0;
        else        pkt_q <= pkt_d;
    end

    assign req_o    = pkt_q.req;
    assign addr_o   = pkt_q.addr;
    assign rset_o   = pkt_q.rset;
    assign level_o  = pkt_q.level;
    assign nmi_o    = pkt_q.nmi;
    assign status_o = pkt_q.status;

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |-> (addr_o == '0 && status_o == '0 && level_o == '0));
    assert_req_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (level_o != '0 && status_o[DATA_W-1]));
    assert_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_i |=> req_o);
    assert_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_i |=> !req_o);
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_IN = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   irq_i,
    input  logic                csr_valid_i,
    input  logic                csr_write_i,
    input  logic [ADDR_W-1:0]   csr_addr_i,
    input  logic [DATA_W-1:0]   csr_wdata_i,
    output logic [DATA_W-1:0]   csr_rdata_o,
    output logic                req_o,
    output logic [DATA_W-1:0]   req_addr_o,
    output logic [FIELD_W-1:0]  req_rset_o,
    output logic [FIELD_W-1:0]  req_level_o,
    output logic                req_nmi_o
);
    localparam int unsigned IDX_W = $clog2(NUM_IN);

    logic [NUM_IN-1:0][DATA_W-1:0] cfg;
    logic [NUM_IN-1:0]             pending;
    logic [DATA_W-1:0]             ctrl, base, status;
    logic                          sel_valid, sel_nmi;
    logic [IDX_W-1:0]              sel_idx;
    logic [FIELD_W-1:0]            sel_level, sel_rset;

    vpic_csr #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .csr_valid_i(csr_valid_i), .csr_write_i(csr_write_i),
        .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .raw_i(irq_i), .status_i(status), .vaddr_i(req_addr_o),
        .cfg_o(cfg), .pending_o(pending), .ctrl_o(ctrl), .base_o(base)
    );

    vpic_pick #(.NUM_IN(NUM_IN)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pending_i(pending), .cfg_i(cfg),
        .sel_valid_o(sel_valid), .sel_idx_o(sel_idx), .sel_level_o(sel_level),
        .sel_rset_o(sel_rset), .sel_nmi_o(sel_nmi)
    );

    vpic_pkt #(.NUM_IN(NUM_IN)) u_pkt (
        .clk(clk), .rst_n(rst_n),
        .sel_valid_i(sel_valid), .sel_idx_i(sel_idx), .sel_level_i(sel_level),
        .sel_rset_i(sel_rset), .sel_nmi_i(sel_nmi),
        .size_sel_i(ctrl[2:0]), .base_i(base),
        .req_o(req_o), .addr_o(req_addr_o), .rset_o(req_rset_o),
        .level_o(req_level_o), .nmi_o(req_nmi_o), .status_o(status)
    );

    // the strobe is raised only for a source that is pending right now or was a cycle ago
    assert_req_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ($past(pending) != '0));
endmodule

// File: tb/vpic_top_bench.sv
module vpic_top_bench;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [31:0] irq;
        logic [31:0] sw;
        logic [31:0] en;
        logic        vld;
        logic [4:0]  idx;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h0000_0008, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd3},
        '{32'h0000_0088, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd7},
        '{32'h0000_1080, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd7},
        '{32'h8000_1000, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd31},
        '{32'h8000_0008, 32'h0, 32'h7FFF_FFFF, 1'b1, 5'd3},
        '{32'h0, 32'h0010_0000, 32'hFFFF_FFFF, 1'b1, 5'd20},
        '{32'h0000_0002, 32'h0, 32'hFFFF_FFFF, 1'b0, 5'd0},
        '{32'h0000_0080, 32'h0000_1000, 32'hFFFF_EFFF, 1'b1, 5'd7},
        '{32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0, 5'd0}
    };

    localparam logic [31:0] BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        csr_valid = 1'b0, csr_write = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0, csr_rdata;
    logic        req, req_nmi;
    logic [31:0] req_addr;
    logic [5:0]  req_rset, req_level;

    int checks = 0, fails = 0;
    logic [5:0] lvl_m [32];
    logic [5:0] rs_m  [32];
    logic       nmi_m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    vpic_top u_vpic_top (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .csr_valid_i(csr_valid), .csr_write_i(csr_write), .csr_addr_i(csr_addr),
        .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .req_o(req), .req_addr_o(req_addr), .req_rset_o(req_rset),
        .req_level_o(req_level), .req_nmi_o(req_nmi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 6'(a); csr_wdata = d;
        @(negedge clk);
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        csr_valid = 1'b1; csr_write = 1'b0; csr_addr = 6'(a);
        #1;
        d = csr_rdata;
        csr_valid = 1'b0;
    endtask

    task automatic prog(input int i, input logic [5:0] l, input logic n, input logic [5:0] r);
        lvl_m[i] = l; nmi_m[i] = n; rs_m[i] = r;
        wr(i, {19'd0, r, n, l});
    endtask

    task automatic check_pkt(input string tag, input logic v, input int idx, input logic [31:0] exp_addr);
        logic [31:0] d;
        chk({tag, " R6 req"}, {31'd0, req}, {31'd0, v});
        chk({tag, " R4 addr"}, req_addr, v ? exp_addr : 32'h0);
        chk({tag, " R6 level"}, {26'd0, req_level}, v ? {26'd0, lvl_m[idx]} : 32'h0);
        chk({tag, " R6 rset"}, {26'd0, req_rset}, v ? {26'd0, rs_m[idx]} : 32'h0);
        chk({tag, " R6 nmi"}, {31'd0, req_nmi}, v ? {31'd0, nmi_m[idx]} : 32'h0);
        rd(41, d);
        chk({tag, " R5 status"}, d, v ? (32'h8000_0000 | 32'(idx)) : 32'h0);
        rd(43, d);
        chk({tag, " R5 vaddr"}, d, v ? exp_addr : 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 32; i++) begin lvl_m[i] = '0; rs_m[i] = '0; nmi_m[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 req", {31'd0, req}, 32'h0);
        for (int a = 0; a < 44; a += 7) begin rd(a, d); chk("R10 reg", d, 32'h0); end
        rd(43, d); chk("R10 vaddr", d, 32'h0);

        // configuration
        prog(3, 6'd5, 1'b0, 6'd1);
        prog(7, 6'd9, 1'b0, 6'd2);
        prog(12, 6'd9, 1'b1, 6'd3);
        prog(20, 6'd2, 1'b0, 6'd4);
        prog(31, 6'd63, 1'b1, 6'd63);
        prog(1, 6'd0, 1'b0, 6'd5);
        wr(42, BASE);
        wr(40, 32'd3);
        rd(12, d); chk("R2 cfg readback", d, {19'd0, 6'd3, 1'b1, 6'd9});

        // vector table walk (R3 R1 R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            wr(32, VECS[v].en);
            wr(37, VECS[v].sw);
            @(negedge clk);
            irq = VECS[v].irq;
            #1;
            rd(35, d);
            chk($sformatf("R1 pending v%0d", v), d, (VECS[v].irq | VECS[v].sw) & VECS[v].en);
            @(negedge clk);
            check_pkt($sformatf("R3 v%0d", v), VECS[v].vld, int'(VECS[v].idx),
                      BASE + (32'(VECS[v].idx) << 5));
        end

        // R11 one-edge latency
        wr(32, 32'hFFFF_FFFF); wr(37, 32'h0);
        @(negedge clk); irq = 32'h0; @(negedge clk);
        irq = 32'h8000_0000; #1;
        chk("R11 before edge", {31'd0, req}, 32'h0);
        @(negedge clk);
        chk("R11 after edge", {31'd0, req}, 32'h1);
        irq = 32'h0; @(negedge clk);

        // R4 entry size variants, upper control bits ignored
        wr(37, 32'h0000_0080);
        wr(40, 32'd0); @(negedge clk);
        chk("R4 size4", req_addr, BASE + 32'd7 * 4);
        wr(40, 32'd7); @(negedge clk);
        chk("R4 size512", req_addr, BASE + 32'd7 * 512);
        wr(40, 32'hFFFF_FFF9); @(negedge clk);
        chk("R4 high ctrl bits", req_addr, BASE + 32'd7 * 8);

        // R7 aliases
        wr(32, 32'h0000_00F0);
        wr(33, 32'h0000_0003); rd(32, d); chk("R7 enable set", d, 32'h0000_00F3);
        wr(34, 32'h0000_0030); rd(32, d); chk("R7 enable clear", d, 32'h0000_00C3);
        wr(37, 32'h0000_0100);
        wr(38, 32'h0000_0011); rd(37, d); chk("R7 sw set", d, 32'h0000_0111);
        wr(39, 32'h0000_0101); rd(37, d); chk("R7 sw clear", d, 32'h0000_0010);

        // R8 alias and unmapped reads, ignored writes
        rd(33, d); chk("R8 alias read", d, 32'h0);
        rd(39, d); chk("R8 alias read sw", d, 32'h0);
        wr(35, 32'hFFFF_FFFF); wr(41, 32'hFFFF_FFFF); wr(43, 32'hFFFF_FFFF); wr(50, 32'hFFFF_FFFF);
        rd(32, d); chk("R8 enable kept", d, 32'h0000_00C3);
        rd(37, d); chk("R8 sw kept", d, 32'h0000_0010);
        rd(42, d); chk("R8 base kept", d, BASE);
        rd(50, d); chk("R8 unmapped read", d, 32'h0);

        // R9 raw status follows lines
        @(negedge clk); irq = 32'hA5A5_0F0F; #1;
        rd(36, d); chk("R9 raw", d, 32'hA5A5_0F0F);
        irq = 32'h0; #1;
        rd(36, d); chk("R9 raw low", d, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule